// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the memory stage of a 32-bit RISC pipeline. For one single-register load or store it forms the byte address to present to memory and the updated base-register value, and it decides whether that update is written back. The addressing fields come already decoded: indexing before or after the access, add or subtract, optional writeback, immediate or register offset, a logical shift on a register offset, the access size and whether a load is signed.

For loads, the word read from memory at the word-aligned address comes in with the request. The block picks the byte or halfword lane out of it with the low address bits, in little-endian order, and zero- or sign-extends the result. For stores it masks the source register down to the access size. All results are registered and come out one cycle after a request strobe, together with a valid flag.

Top module: `lsu_addr_gen`

## Requirements
- R1: The outputs `out_valid`, `eff_addr`, `wb_value`, `wb_en`, `load_data` and `store_data` are updated on the clock edge that samples `req_valid` high. `out_valid` is high in exactly the cycle after a request cycle. `wb_en` is never high while `out_valid` is low.
- R2: With `pre_index`=1 the address is base+offset when `add_dir`=1 and base-offset when `add_dir`=0. `wb_value` carries that same sum. `wb_en` is high only when `wb_req`=1.
- R3: With `pre_index`=0 the address is the unmodified base. `wb_value` is base plus or minus the offset. `wb_en` is high whatever the value of `wb_req`.
- R4: For a wide access (byte or word, unsigned) with `use_reg`=0, the offset is `imm_field[11:0]` taken as an unsigned value from 0 to 4095.
- R5: For a wide access with `use_reg`=1, the offset is `off_reg` shifted by `shift_amt` (0 to 31). The shift is logical left when `shift_right`=0 and logical right when `shift_right`=1.
- R6: For a narrow access (halfword size, or `acc_signed`=1), an immediate offset is only `imm_field[7:0]` (0 to 255), so bits 11:8 are ignored. A register offset is used unshifted, so `shift_amt` and `shift_right` are ignored.
- R7: When `base_is_pc`=1 the base is `pc_val`+8 and `base_val` is ignored.
- R8: When `base_is_pc`=1, `wb_en` stays low in every mode.
- R9: For a byte access (`acc_size`=2'b00), address bits 1:0 select `mem_rdata` byte lane 0..3, lane n being bits 8n+7:8n. The result is zero-extended, or sign-extended when `acc_signed`=1.
- R10: For a halfword access (`acc_size`=2'b01), address bit 1 selects bits 31:16 (1) or 15:0 (0) of `mem_rdata`. The result is zero- or sign-extended as `acc_signed` says. For a word access (`acc_size`=2'b10 or 2'b11), `load_data` is `mem_rdata`.
- R11: `store_data` is `store_src` with all bits above the access size cleared: bits 7:0 kept for a byte and bits 15:0 kept for a halfword.
- R12: While `rst` is high every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| pc_val | input | 32 | Address of the current instruction |
| off_reg | input | 32 | Offset register value |
| imm_field | input | 12 | Immediate offset magnitude |
| pre_index | input | 1 | 1: index before access, 0: after |
| add_dir | input | 1 | 1: add offset, 0: subtract |
| wb_req | input | 1 | Writeback requested (pre-index only) |
| use_reg | input | 1 | Offset from register instead of immediate |
| shift_right | input | 1 | Register offset shift direction |
| shift_amt | input | 5 | Register offset shift amount |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_signed | input | 1 | Signed load |
| mem_rdata | input | 32 | Memory word at the aligned address |
| store_src | input | 32 | Store source register value |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective address |
| wb_value | output | 32 | New base-register value |
| wb_en | output | 1 | Base writeback enable |
| load_data | output | 32 | Aligned and extended load data |
| store_data | output | 32 | Size-masked store data |

## Verification
In the same cycle the block both selects a load lane from the address and produces a writeback value that differs from that address. In post-index mode the lane must come from the unmodified base while `wb_value` carries the offset sum. In pre-index mode both must follow the sum. The sweep runs every indexing mode against bases whose low two bits cover all four lanes, and against offsets that move the lane. For each vector it compares the lane-extracted load data and the writeback value against expectations computed separately from the base and from the sum, so a lane taken from the wrong one of the two is exposed.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    localparam int DATA_W      = 32;
    localparam int IMM_WIDE_W  = 12;
    localparam int IMM_NARROW_W = 8;
    localparam int PC_AHEAD    = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic       pre;
        logic       up;
        logic       wb;
        logic       use_reg;
        logic       shr;
        logic [4:0] shamt;
    } addr_mode_t;

    function automatic logic is_narrow(input acc_size_e sz, input logic sgn);
        return (sz == SZ_HALF) || sgn;
    endfunction
endpackage

// File: rtl/lsag_offset.sv
module lsag_offset
    import lsag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_WIDE_W,
    parameter int NW = IMM_NARROW_W,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] reg_val,
    input  logic [IW-1:0] imm,
    input  logic          use_reg,
    input  logic          shr,
    input  logic [SW-1:0] shamt,
    input  logic          narrow,
    output logic [DW-1:0] offset
);
    logic [DW-1:0] wide_imm, narrow_imm, shifted;

    assign wide_imm   = {{(DW-IW){1'b0}}, imm};
    assign narrow_imm = {{(DW-NW){1'b0}}, imm[NW-1:0]};
    assign shifted    = shr ? (reg_val >> shamt) : (reg_val << shamt);

    always_comb begin
        if (use_reg) offset = narrow ? reg_val : shifted;
        else         offset = narrow ? narrow_imm : wide_imm;
    end
endmodule

// File: rtl/lsag_adder.sv
module lsag_adder
    import lsag_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] offset,
    input  logic          up,
    input  logic          pre,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] sum
);
    assign sum  = up ? (base + offset) : (base - offset);
    assign addr = pre ? sum : base;
endmodule

// File: rtl/lsag_align.sv
module lsag_align
    import lsag_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int LANES = DW / 8,
    localparam int LW = $clog2(LANES),
    localparam int HALVES = LANES / 2
) (
    input  logic [DW-1:0] word,
    input  logic [LW-1:0] lane,
    input  acc_size_e     size,
    input  logic          sgn,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] load_out,
    output logic [DW-1:0] store_out
);
    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HALVES];

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign byte_lane[i] = word[8*i +: 8];
    end
    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign half_lane[j] = word[16*j +: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    assign sel_b = byte_lane[lane];
    assign sel_h = half_lane[lane[LW-1:1]];

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                load_out  = {{(DW-8){sgn & sel_b[7]}}, sel_b};
                store_out = {{(DW-8){1'b0}}, src[7:0]};
            end
            SZ_HALF: begin
                load_out  = {{(DW-16){sgn & sel_h[15]}}, sel_h};
                store_out = {{(DW-16){1'b0}}, src[15:0]};
            end
            default: begin
                load_out  = word;
                store_out = src;
            end
        endcase
    end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsag_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int SW = $clog2(DW),
    localparam int LW = $clog2(DW / 8)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [DW-1:0] base_val,
    input  logic          base_is_pc,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] off_reg,
    input  logic [11:0]   imm_field,
    input  logic          pre_index,
    input  logic          add_dir,
    input  logic          wb_req,
    input  logic          use_reg,
    input  logic          shift_right,
    input  logic [SW-1:0] shift_amt,
    input  logic [1:0]    acc_size,
    input  logic          acc_signed,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] store_src,
    output logic          out_valid,
    output logic [DW-1:0] eff_addr,
    output logic [DW-1:0] wb_value,
    output logic          wb_en,
    output logic [DW-1:0] load_data,
    output logic [DW-1:0] store_data
);
    addr_mode_t mode;
    acc_size_e  size;
    logic       narrow;
    logic [DW-1:0] base_eff, offset, addr_c, sum_c, load_c, store_c;
    logic       wb_c;

    assign mode = '{pre: pre_index, up: add_dir, wb: wb_req, use_reg: use_reg,
                    shr: shift_right, shamt: shift_amt};
    assign size   = acc_size_e'(acc_size);
    assign narrow = is_narrow(size, acc_signed);
    assign base_eff = base_is_pc ? (pc_val + DW'(PC_AHEAD)) : base_val;
    assign wb_c   = (!mode.pre || mode.wb) && !base_is_pc;

    lsag_offset #(.DW(DW)) u_off (
        .reg_val(off_reg), .imm(imm_field), .use_reg(mode.use_reg),
        .shr(mode.shr), .shamt(mode.shamt), .narrow(narrow), .offset(offset)
    );

    lsag_adder #(.DW(DW)) u_add (
        .base(base_eff), .offset(offset), .up(mode.up), .pre(mode.pre),
        .addr(addr_c), .sum(sum_c)
    );

    lsag_align #(.DW(DW)) u_aln (
        .word(mem_rdata), .lane(addr_c[LW-1:0]), .size(size), .sgn(acc_signed),
        .src(store_src), .load_out(load_c), .store_out(store_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            wb_en      <= 1'b0;
            eff_addr   <= '0;
            wb_value   <= '0;
            load_data  <= '0;
            store_data <= '0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid && wb_c;
            if (req_valid) begin
                eff_addr   <= addr_c;
                wb_value   <= sum_c;
                load_data  <= load_c;
                store_data <= store_c;
            end
        end
    end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          base_is_pc,
    input logic          pre_index,
    input logic [DW-1:0] base_val,
    input logic [1:0]    acc_size,
    input logic          acc_signed,
    input logic          out_valid,
    input logic          wb_en,
    input logic [DW-1:0] eff_addr,
    input logic [DW-1:0] load_data,
    input logic [DW-1:0] store_data
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    // R1
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> out_valid);
    // R8
    pc_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && base_is_pc) |=> !wb_en);
    // R3
    post_forces_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pre_index && !base_is_pc) |=> wb_en);
    // R3
    post_addr_base_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pre_index && !base_is_pc) |=> (eff_addr == $past(base_val)));
    // R9
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_size == 2'b00 && !acc_signed) |=> (load_data[DW-1:8] == '0));
    // R11
    byte_store_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_size == 2'b00) |=> (store_data[DW-1:8] == '0));
endmodule

bind lsu_addr_gen lsag_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .base_is_pc(base_is_pc),
    .pre_index(pre_index), .base_val(base_val), .acc_size(acc_size),
    .acc_signed(acc_signed), .out_valid(out_valid), .wb_en(wb_en),
    .eff_addr(eff_addr), .load_data(load_data), .store_data(store_data)
);

// File: tb/lsu_addr_gen_test.sv
module lsu_addr_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] base_val, pc_val, off_reg, mem_rdata, store_src;
    logic        base_is_pc, pre_index, add_dir, wb_req, use_reg, shift_right, acc_signed;
    logic [11:0] imm_field;
    logic [4:0]  shift_amt;
    logic [1:0]  acc_size;
    logic        out_valid, wb_en;
    logic [31:0] eff_addr, wb_value, load_data, store_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_addr_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_val(base_val),
        .base_is_pc(base_is_pc), .pc_val(pc_val), .off_reg(off_reg),
        .imm_field(imm_field), .pre_index(pre_index), .add_dir(add_dir),
        .wb_req(wb_req), .use_reg(use_reg), .shift_right(shift_right),
        .shift_amt(shift_amt), .acc_size(acc_size), .acc_signed(acc_signed),
        .mem_rdata(mem_rdata), .store_src(store_src), .out_valid(out_valid),
        .eff_addr(eff_addr), .wb_value(wb_value), .wb_en(wb_en),
        .load_data(load_data), .store_data(store_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected results computed from the requirement text.
    logic [31:0] x_ea, x_wbv, x_ld, x_st;
    logic        x_wbe;
    task automatic expect_calc();
        logic [31:0] b, off, s, hw;
        logic [7:0]  by;
        bit narrow;
        narrow = (acc_size == 2'b01) || acc_signed;
        b = base_is_pc ? pc_val + 32'd8 : base_val;
        if (use_reg) off = narrow ? off_reg : (shift_right ? off_reg >> shift_amt : off_reg << shift_amt);
        else         off = narrow ? {24'd0, imm_field[7:0]} : {20'd0, imm_field};
        s = add_dir ? b + off : b - off;
        x_ea  = pre_index ? s : b;
        x_wbv = s;
        x_wbe = (!pre_index || wb_req) && !base_is_pc;
        by = mem_rdata[8*x_ea[1:0] +: 8];
        hw = x_ea[1] ? {16'd0, mem_rdata[31:16]} : {16'd0, mem_rdata[15:0]};
        case (acc_size)
            2'b00: begin
                x_ld = acc_signed ? {{24{by[7]}}, by} : {24'd0, by};
                x_st = {24'd0, store_src[7:0]};
            end
            2'b01: begin
                x_ld = acc_signed ? {{16{hw[15]}}, hw[15:0]} : hw;
                x_st = {16'd0, store_src[15:0]};
            end
            default: begin
                x_ld = mem_rdata;
                x_st = store_src;
            end
        endcase
    endtask

    // Drive is set up by caller at a negedge; this issues one request and checks.
    task automatic issue_and_check();
        expect_calc();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 out_valid", {31'd0, out_valid}, 32'd1);
        check(pre_index ? "R2 eff_addr" : "R3 eff_addr", eff_addr, x_ea);
        check(pre_index ? "R2 wb_value" : "R3 wb_value", wb_value, x_wbv);
        check(base_is_pc ? "R8 wb_en" : (pre_index ? "R2 wb_en" : "R3 wb_en"),
              {31'd0, wb_en}, {31'd0, x_wbe});
        check(acc_size == 2'b00 ? "R9 load_data" : "R10 load_data", load_data, x_ld);
        check("R11 store_data", store_data, x_st);
    endtask

    task automatic set_defaults();
        base_val = 32'h0000_2000; base_is_pc = 0; pc_val = 32'h0000_4006;
        off_reg = 32'h0000_0C03; imm_field = 12'hA5E; pre_index = 1; add_dir = 1;
        wb_req = 0; use_reg = 0; shift_right = 0; shift_amt = 0; acc_size = 2'b10;
        acc_signed = 0; mem_rdata = 32'h8C7A_F513; store_src = 32'hDEAD_BEEF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [4];
        logic [4:0]  shs [4];
        logic [31:0] pats [2];
        bases = '{32'h0000_2000, 32'h0000_1001, 32'hFFFF_FFF2, 32'h0000_0103};
        shs   = '{5'd0, 5'd2, 5'd7, 5'd31};
        pats  = '{32'h8C7A_F513, 32'h7F80_01FE};
        set_defaults();
        req_valid = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 out_valid", {31'd0, out_valid}, 32'd0);
        check("R12 wb_en", {31'd0, wb_en}, 32'd0);
        check("R12 eff_addr", eff_addr, 32'd0);
        check("R12 load_data", load_data, 32'd0);
        rst = 0;

        // Directed: R4 maximal 12-bit immediate subtracted
        set_defaults(); imm_field = 12'hFFF; add_dir = 0;
        issue_and_check();
        check("R4 max imm subtract", eff_addr, 32'h0000_2000 - 32'd4095);
        // Directed: R5 register shifted right by 31
        set_defaults(); use_reg = 1; shift_right = 1; shift_amt = 5'd31; off_reg = 32'h8000_0000;
        issue_and_check();
        check("R5 shift right 31", eff_addr, 32'h0000_2001);
        set_defaults(); use_reg = 1; shift_amt = 5'd4; off_reg = 32'h0000_0003;
        issue_and_check();
        check("R5 shift left 4", eff_addr, 32'h0000_2030);
        // Directed: R6 narrow immediate ignores bits 11:8, register unshifted
        set_defaults(); acc_size = 2'b01; imm_field = 12'hFFF;
        issue_and_check();
        check("R6 narrow imm", eff_addr, 32'h0000_20FF);
        set_defaults(); acc_size = 2'b00; acc_signed = 1; use_reg = 1; shift_amt = 5'd9;
        issue_and_check();
        check("R6 narrow reg unshifted", eff_addr, 32'h0000_2C03);
        // Directed: R7 PC base, base_val ignored, R8 no writeback
        set_defaults(); base_is_pc = 1; pre_index = 0; base_val = 32'h1234_5678;
        issue_and_check();
        check("R7 pc base", eff_addr, 32'h0000_400E);
        check("R8 pc post no wb", {31'd0, wb_en}, 32'd0);
        // R1: no request, valid drops and no writeback
        @(negedge clk);
        check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 idle wb_en", {31'd0, wb_en}, 32'd0);

        // Sweep
        for (int pr = 0; pr < 2; pr++)
        for (int up = 0; up < 2; up++)
        for (int wb = 0; wb < 2; wb++)
        for (int ur = 0; ur < 2; ur++)
        for (int sd = 0; sd < 2; sd++)
        for (int sz = 0; sz < 5; sz++)
        for (int pc = 0; pc < 2; pc++)
        for (int bi = 0; bi < 4; bi++)
        for (int si = 0; si < 4; si++) begin
            set_defaults();
            pre_index = pr[0]; add_dir = up[0]; wb_req = wb[0]; use_reg = ur[0];
            shift_right = sd[0]; base_is_pc = pc[0]; base_val = bases[bi];
            shift_amt = shs[si];
            off_reg = 32'h0000_0C03 + 32'(si);
            imm_field = 12'hA5C + 12'(si);
            pc_val = 32'h0000_4004 + 32'(bi);
            mem_rdata = pats[(bi + si) % 2];
            store_src = 32'hDEAD_BEEF ^ {bi[7:0], si[7:0], 16'h0};
            case (sz)
                0: begin acc_size = 2'b00; acc_signed = 0; end
                1: begin acc_size = 2'b00; acc_signed = 1; end
                2: begin acc_size = 2'b01; acc_signed = 0; end
                3: begin acc_size = 2'b01; acc_signed = 1; end
                default: begin acc_size = 2'b10; acc_signed = 0; end
            endcase
            issue_and_check();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule